// File: doc/BRIEF.md
# Phased Expansion Bus Controller

This controller bridges a single-outstanding internal request port to an external asynchronous expansion bus with eight chip-select lines. A request names a chip select, a byte offset within that bank, a direction and a size. The controller steps through five bus phases in a fixed order: address, select setup, strobe, hold and recovery. It drives the select line, the strobes, the address and the data while it does so. At the end it returns a one-cycle completion pulse, together with read data or an error flag.

Every chip select has its own settings, supplied on configuration input ports:
- extra cycles for each phase;
- a strobe style;
- 8-bit or 16-bit device width;
- permission for byte reads on 16-bit devices;
- address/data multiplexing;
- write permission;
- the active level of a ready input, used only by the host-port style.

A request that breaks the chip select's settings never reaches the bus. It completes with the error flag set.

Top module: `exbus_ctrl`

## Requirements
- R1: At most one of the eight active-low lines `bus_cs_n` is low at any time. The line that goes low is the one numbered by `req_cs` of the request being served.
- R2: A served request passes through address, setup, strobe, hold and recovery in that order. Each phase lasts 1 plus its extension count: address and setup and hold take 0..3 extra cycles, strobe and recovery take 0..15. `req_ready` is low from the cycle after acceptance until recovery ends.
- R3: The selected `bus_cs_n` line is low from the first setup cycle through the last hold cycle. It is high during the address and recovery phases.
- R4: With style code 0 (split strobes), `bus_rd_n` (read) or `bus_wr_n` (write) is low for exactly the strobe phase, and `bus_ds_n` stays high.
- R5: With style code 1 (single strobe), `bus_ds_n` is low for exactly the strobe phase. `bus_rnw` is low while the select is active for a write and high for a read. `bus_rd_n` and `bus_wr_n` stay high.
- R6: With style code 2 (host port), the strobe is driven as in R5. The strobe phase lasts at least 1 plus its extension and continues until `bus_ready` equals the chip select's polarity bit (1 means ready is active high).
- R7: When the multiplex bit is set, `bus_ale` is high for the whole address phase, and the data bus drives the low 16 bits of the address with `bus_d_oe` high.
- R8: For an 8-bit device, writes drive `{8'h00, wdata[7:0]}` and reads return `{8'h00, d_in[7:0]}`. A byte access to a 16-bit device uses lane `d[15:8]` when address bit 0 is 1 and lane `d[7:0]` otherwise, and read data is returned right-aligned with zero upper bits. A 16-bit access uses all 16 bits.
- R9: A write to a chip select whose write-enable bit is 0 produces no select, no strobe and no data drive. It completes with `rsp_done` and `rsp_err` high one cycle after the busy cycle, with `rsp_rdata` equal to 0.
- R10: The same error completion as R9 occurs for a byte read to a 16-bit device whose byte-read bit is 0, and for any request to a chip select whose style code is 3.
- R11: `rsp_done` is a one-cycle pulse in the first idle cycle after recovery. `rsp_rdata` then holds the read data, or 0 for a write. `rsp_err` is high only together with `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request taken when both are high |
| req_cs | input | CSW | Chip select number |
| req_addr | input | AW | Offset within the bank |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = 16-bit access |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | Completion pulse |
| rsp_err | output | 1 | Error flag, valid with rsp_done |
| rsp_rdata | output | 16 | Read data, valid with rsp_done |
| cfg_t_addr | input | 2*NCS | Address-phase extension, 2 bits per select |
| cfg_t_setup | input | 2*NCS | Setup-phase extension |
| cfg_t_strobe | input | 4*NCS | Strobe-phase extension |
| cfg_t_hold | input | 2*NCS | Hold-phase extension |
| cfg_t_recov | input | 4*NCS | Recovery-phase extension |
| cfg_style | input | 2*NCS | Strobe style code per select |
| cfg_narrow | input | NCS | 1 = 8-bit device |
| cfg_byte_rd16 | input | NCS | 1 = byte reads allowed on a 16-bit device |
| cfg_mux | input | NCS | 1 = address multiplexed on data bus |
| cfg_wr_en | input | NCS | 1 = writes allowed |
| cfg_rdy_hi | input | NCS | Ready polarity for host-port style |
| bus_cs_n | output | NCS | Active-low chip selects |
| bus_addr | output | AW | Bus address |
| bus_ale | output | 1 | Address valid on data bus (multiplex mode) |
| bus_d_out | output | 16 | Data bus output value |
| bus_d_oe | output | 1 | Data bus output enable |
| bus_d_in | input | 16 | Data bus input value |
| bus_rd_n | output | 1 | Read strobe, split style |
| bus_wr_n | output | 1 | Write strobe, split style |
| bus_ds_n | output | 1 | Data strobe, single and host-port styles |
| bus_rnw | output | 1 | Read/not-write, single and host-port styles |
| bus_ready | input | 1 | Ready from the device, host-port style |

## Verification
The bench first runs zero-extension reads and writes, which pin down the minimum phase lengths. Chip selects with unequal extensions on every phase follow; they show whether each count feeds its own phase. The maximum strobe and recovery counts test the widest counter values.

Host-port transfers use both ready polarities, with ready arriving both before and after the strobe count runs out. This separates "wait for ready" from "wait for the count". Byte accesses at even and odd offsets, on both 8-bit and 16-bit devices, tell the lanes apart. Writes with writes disabled, unpermitted byte reads and the reserved style code show that an error completion never touches the bus.

// File: rtl/exbus_pkg.sv
package exbus_pkg;

    localparam int DW   = 16;
    localparam int EXTW = 4;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_SETUP, PH_STROBE, PH_HOLD, PH_RECOV, PH_FAULT
    } phase_e;

    typedef enum logic [1:0] {
        STY_SPLIT = 2'd0,
        STY_DS    = 2'd1,
        STY_HOST  = 2'd2,
        STY_RSVD  = 2'd3
    } style_e;

    typedef struct packed {
        logic [1:0] t_addr;
        logic [1:0] t_setup;
        logic [3:0] t_strobe;
        logic [1:0] t_hold;
        logic [3:0] t_recov;
        style_e     style;
        logic       narrow;
        logic       byte_rd16;
        logic       mux;
        logic       wr_en;
        logic       rdy_hi;
    } cs_cfg_t;

    function automatic logic req_fault(cs_cfg_t c, logic wr, logic byt);
        return (c.style == STY_RSVD) || (wr && !c.wr_en) ||
               (!wr && byt && !c.narrow && !c.byte_rd16);
    endfunction

    function automatic logic [DW-1:0] wr_lanes(cs_cfg_t c, logic byt, logic a0,
                                               logic [DW-1:0] w);
        if (c.narrow)   return {8'h00, w[7:0]};
        else if (byt)   return a0 ? {w[7:0], 8'h00} : {8'h00, w[7:0]};
        else            return w;
    endfunction

    function automatic logic [DW-1:0] rd_lanes(cs_cfg_t c, logic byt, logic a0,
                                               logic [DW-1:0] d);
        if (c.narrow)   return {8'h00, d[7:0]};
        else if (byt)   return a0 ? {8'h00, d[15:8]} : {8'h00, d[7:0]};
        else            return d;
    endfunction

endpackage

// File: rtl/exbus_cfg_sel.sv
module exbus_cfg_sel
    import exbus_pkg::*;
#(
    parameter int NCS = 8,
    parameter int CSW = $clog2(NCS)
) (
    input  logic [2*NCS-1:0] t_addr,
    input  logic [2*NCS-1:0] t_setup,
    input  logic [4*NCS-1:0] t_strobe,
    input  logic [2*NCS-1:0] t_hold,
    input  logic [4*NCS-1:0] t_recov,
    input  logic [2*NCS-1:0] style,
    input  logic [NCS-1:0]   narrow,
    input  logic [NCS-1:0]   byte_rd16,
    input  logic [NCS-1:0]   mux,
    input  logic [NCS-1:0]   wr_en,
    input  logic [NCS-1:0]   rdy_hi,
    input  logic [CSW-1:0]   sel,
    output cs_cfg_t          cfg
);

    cs_cfg_t tbl [NCS];

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign tbl[i].t_addr    = t_addr[2*i +: 2];
        assign tbl[i].t_setup   = t_setup[2*i +: 2];
        assign tbl[i].t_strobe  = t_strobe[4*i +: 4];
        assign tbl[i].t_hold    = t_hold[2*i +: 2];
        assign tbl[i].t_recov   = t_recov[4*i +: 4];
        assign tbl[i].style     = style_e'(style[2*i +: 2]);
        assign tbl[i].narrow    = narrow[i];
        assign tbl[i].byte_rd16 = byte_rd16[i];
        assign tbl[i].mux       = mux[i];
        assign tbl[i].wr_en     = wr_en[i];
        assign tbl[i].rdy_hi    = rdy_hi[i];
    end

    assign cfg = tbl[sel];

endmodule

// File: rtl/exbus_phase_fsm.sv
module exbus_phase_fsm
    import exbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    fault,
    input  cs_cfg_t cfg_in,
    input  logic    ready_in,
    output phase_e  ph,
    output cs_cfg_t cfg_q,
    output logic    strobe_exit,
    output logic    done
);

    logic [EXTW-1:0] cnt;
    logic            rdy_act;

    assign rdy_act     = (ready_in == cfg_q.rdy_hi);
    assign strobe_exit = (ph == PH_STROBE) && (cnt == '0) &&
                         ((cfg_q.style != STY_HOST) || rdy_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph    <= PH_IDLE;
            cnt   <= '0;
            cfg_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (ph)
                PH_IDLE: if (start) begin
                    cfg_q <= cfg_in;
                    if (fault) ph <= PH_FAULT;
                    else begin
                        ph  <= PH_ADDR;
                        cnt <= {2'b00, cfg_in.t_addr};
                    end
                end
                PH_FAULT: begin
                    ph   <= PH_IDLE;
                    done <= 1'b1;
                end
                PH_ADDR: if (cnt == '0) begin
                    ph  <= PH_SETUP;
                    cnt <= {2'b00, cfg_q.t_setup};
                end else cnt <= cnt - 1'b1;
                PH_SETUP: if (cnt == '0) begin
                    ph  <= PH_STROBE;
                    cnt <= cfg_q.t_strobe;
                end else cnt <= cnt - 1'b1;
                PH_STROBE: if (strobe_exit) begin
                    ph  <= PH_HOLD;
                    cnt <= {2'b00, cfg_q.t_hold};
                end else if (cnt != '0) cnt <= cnt - 1'b1;
                PH_HOLD: if (cnt == '0) begin
                    ph  <= PH_RECOV;
                    cnt <= cfg_q.t_recov;
                end else cnt <= cnt - 1'b1;
                PH_RECOV: if (cnt == '0) begin
                    ph   <= PH_IDLE;
                    done <= 1'b1;
                end else cnt <= cnt - 1'b1;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    // R2
    addr_order_chk: assert property (@(posedge clk) disable iff (rst)
        ph == PH_ADDR |=> (ph == PH_ADDR || ph == PH_SETUP));
    // R2
    setup_order_chk: assert property (@(posedge clk) disable iff (rst)
        ph == PH_SETUP |=> (ph == PH_SETUP || ph == PH_STROBE));
    // R2
    strobe_order_chk: assert property (@(posedge clk) disable iff (rst)
        ph == PH_STROBE |=> (ph == PH_STROBE || ph == PH_HOLD));
    // R2
    hold_order_chk: assert property (@(posedge clk) disable iff (rst)
        ph == PH_HOLD |=> (ph == PH_HOLD || ph == PH_RECOV));
    // R6
    host_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_STROBE && cfg_q.style == STY_HOST && ready_in != cfg_q.rdy_hi)
        |=> ph == PH_STROBE);
    // R11
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(ph) == PH_RECOV || $past(ph) == PH_FAULT));

endmodule

// File: rtl/exbus_pins.sv
module exbus_pins
    import exbus_pkg::*;
#(
    parameter int NCS = 8,
    parameter int CSW = $clog2(NCS),
    parameter int AW  = 24
) (
    input  logic           clk,
    input  logic           rst,
    input  phase_e         ph,
    input  cs_cfg_t        cfg_q,
    input  logic [CSW-1:0] cs_q,
    input  logic [AW-1:0]  addr_q,
    input  logic           wr_q,
    input  logic           byt_q,
    input  logic [DW-1:0]  wdata_q,
    output logic [NCS-1:0] cs_n,
    output logic [AW-1:0]  addr,
    output logic           ale,
    output logic [DW-1:0]  d_out,
    output logic           d_oe,
    output logic           rd_n,
    output logic           wr_n,
    output logic           ds_n,
    output logic           rnw
);

    logic cs_on, stb, split;

    assign cs_on = (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
    assign stb   = (ph == PH_STROBE);
    assign split = (cfg_q.style == STY_SPLIT);

    for (genvar i = 0; i < NCS; i++) begin : g_sel
        assign cs_n[i] = !(cs_on && cs_q == CSW'(i));
    end

    assign addr = (ph == PH_IDLE || ph == PH_FAULT) ? '0 : addr_q;
    assign ale  = cfg_q.mux && (ph == PH_ADDR);

    always_comb begin
        d_out = '0;
        d_oe  = 1'b0;
        if (ale) begin
            d_out = addr_q[DW-1:0];
            d_oe  = 1'b1;
        end else if (wr_q && cs_on) begin
            d_out = wr_lanes(cfg_q, byt_q, addr_q[0], wdata_q);
            d_oe  = 1'b1;
        end
    end

    assign rd_n = !(stb && split && !wr_q);
    assign wr_n = !(stb && split && wr_q);
    assign ds_n = !(stb && !split);
    assign rnw  = !(wr_q && cs_on && !split);

    // R1
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));
    // R3
    cs_idle_edges_chk: assert property (@(posedge clk) disable iff (rst)
        (ph == PH_ADDR || ph == PH_RECOV) |-> (&cs_n));
    // R4
    split_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (ds_n && !(&cs_n)));

endmodule

// File: rtl/exbus_ctrl.sv
module exbus_ctrl
    import exbus_pkg::*;
#(
    parameter int NCS = 8,
    parameter int AW  = 24,
    parameter int CSW = $clog2(NCS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [CSW-1:0]   req_cs,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    input  logic             req_byte,
    input  logic [15:0]      req_wdata,
    output logic             rsp_done,
    output logic             rsp_err,
    output logic [15:0]      rsp_rdata,
    input  logic [2*NCS-1:0] cfg_t_addr,
    input  logic [2*NCS-1:0] cfg_t_setup,
    input  logic [4*NCS-1:0] cfg_t_strobe,
    input  logic [2*NCS-1:0] cfg_t_hold,
    input  logic [4*NCS-1:0] cfg_t_recov,
    input  logic [2*NCS-1:0] cfg_style,
    input  logic [NCS-1:0]   cfg_narrow,
    input  logic [NCS-1:0]   cfg_byte_rd16,
    input  logic [NCS-1:0]   cfg_mux,
    input  logic [NCS-1:0]   cfg_wr_en,
    input  logic [NCS-1:0]   cfg_rdy_hi,
    output logic [NCS-1:0]   bus_cs_n,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_ale,
    output logic [15:0]      bus_d_out,
    output logic             bus_d_oe,
    input  logic [15:0]      bus_d_in,
    output logic             bus_rd_n,
    output logic             bus_wr_n,
    output logic             bus_ds_n,
    output logic             bus_rnw,
    input  logic             bus_ready
);

    cs_cfg_t        cfg_now, cfg_q;
    phase_e         ph;
    logic           accept, fault_now, strobe_exit, done;
    logic [CSW-1:0] cs_q;
    logic [AW-1:0]  addr_q;
    logic           wr_q, byt_q, fault_q;
    logic [DW-1:0]  wdata_q, rdata_q;

    exbus_cfg_sel #(.NCS(NCS), .CSW(CSW)) u_sel (
        .t_addr(cfg_t_addr), .t_setup(cfg_t_setup), .t_strobe(cfg_t_strobe),
        .t_hold(cfg_t_hold), .t_recov(cfg_t_recov), .style(cfg_style),
        .narrow(cfg_narrow), .byte_rd16(cfg_byte_rd16), .mux(cfg_mux),
        .wr_en(cfg_wr_en), .rdy_hi(cfg_rdy_hi), .sel(req_cs), .cfg(cfg_now)
    );

    assign req_ready = (ph == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign fault_now = req_fault(cfg_now, req_write, req_byte);

    exbus_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .start(accept), .fault(fault_now),
        .cfg_in(cfg_now), .ready_in(bus_ready), .ph(ph), .cfg_q(cfg_q),
        .strobe_exit(strobe_exit), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= '0;
            addr_q  <= '0;
            wr_q    <= 1'b0;
            byt_q   <= 1'b0;
            wdata_q <= '0;
            fault_q <= 1'b0;
            rdata_q <= '0;
        end else if (accept) begin
            cs_q    <= req_cs;
            addr_q  <= req_addr;
            wr_q    <= req_write;
            byt_q   <= req_byte;
            wdata_q <= req_wdata;
            fault_q <= fault_now;
            rdata_q <= '0;
        end else if (strobe_exit && !wr_q) begin
            rdata_q <= rd_lanes(cfg_q, byt_q, addr_q[0], bus_d_in);
        end
    end

    exbus_pins #(.NCS(NCS), .CSW(CSW), .AW(AW)) u_pins (
        .clk(clk), .rst(rst), .ph(ph), .cfg_q(cfg_q), .cs_q(cs_q),
        .addr_q(addr_q), .wr_q(wr_q), .byt_q(byt_q), .wdata_q(wdata_q),
        .cs_n(bus_cs_n), .addr(bus_addr), .ale(bus_ale), .d_out(bus_d_out),
        .d_oe(bus_d_oe), .rd_n(bus_rd_n), .wr_n(bus_wr_n), .ds_n(bus_ds_n),
        .rnw(bus_rnw)
    );

    assign rsp_done  = done;
    assign rsp_err   = done && fault_q;
    assign rsp_rdata = rdata_q;

    // R9
    no_wr_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr_n || (!bus_ds_n && !bus_rnw)) |-> cfg_q.wr_en);
    // R11
    err_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);

endmodule

// File: tb/sim_exbus_ctrl.sv
module sim_exbus_ctrl;

    localparam int NCS = 8;
    localparam int AW  = 24;

    typedef struct packed {
        logic        err;
        logic        wr;
        logic [15:0] rdata;
        logic [15:0] aled;
        logic [15:0] wd;
        logic [7:0]  csmask;
        logic [15:0] busy;
        logic [15:0] csc;
        logic [15:0] rdc;
        logic [15:0] wrc;
        logic [15:0] dsc;
        logic [15:0] dswc;
        logic [15:0] alec;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_cs = '0;
    logic [AW-1:0]    req_addr = '0;
    logic             req_write = 1'b0;
    logic             req_byte = 1'b0;
    logic [15:0]      req_wdata = '0;
    logic             rsp_done, rsp_err;
    logic [15:0]      rsp_rdata;
    logic [2*NCS-1:0] cfg_t_addr, cfg_t_setup, cfg_t_hold, cfg_style;
    logic [4*NCS-1:0] cfg_t_strobe, cfg_t_recov;
    logic [NCS-1:0]   cfg_narrow, cfg_byte_rd16, cfg_mux, cfg_wr_en, cfg_rdy_hi;
    logic [NCS-1:0]   bus_cs_n;
    logic [AW-1:0]    bus_addr;
    logic             bus_ale, bus_d_oe, bus_rd_n, bus_wr_n, bus_ds_n, bus_rnw;
    logic [15:0]      bus_d_out, bus_d_in;
    logic             bus_ready;

    logic [1:0] ta [NCS], ts [NCS], th [NCS], sty [NCS];
    logic [3:0] tst [NCS], tr [NCS];
    logic       nar [NCS], b16 [NCS], mx [NCS], we [NCS], rh [NCS];

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            cfg_t_addr[2*i +: 2]   = ta[i];
            cfg_t_setup[2*i +: 2]  = ts[i];
            cfg_t_hold[2*i +: 2]   = th[i];
            cfg_style[2*i +: 2]    = sty[i];
            cfg_t_strobe[4*i +: 4] = tst[i];
            cfg_t_recov[4*i +: 4]  = tr[i];
            cfg_narrow[i]    = nar[i];
            cfg_byte_rd16[i] = b16[i];
            cfg_mux[i]       = mx[i];
            cfg_wr_en[i]     = we[i];
            cfg_rdy_hi[i]    = rh[i];
        end
    end

    // device model: read value derived from the address, ready after a delay
    int   rdy_wait = 0;
    logic cur_pol  = 1'b1;
    int   stb_run  = 0;
    assign bus_d_in  = bus_addr[15:0] ^ 16'h5A3C;
    assign bus_ready = (stb_run >= rdy_wait) ? cur_pol : !cur_pol;
    always @(posedge clk) stb_run <= (!bus_ds_n) ? stb_run + 1 : 0;

    exbus_ctrl #(.NCS(NCS), .AW(AW)) u0 (.*);

    int   nchk = 0, nerr = 0;
    exp_t q [$];

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
    endtask

    // driver: computes the expected outcome and issues the request
    task automatic send(input int cs, input bit wr, input bit byt,
                        input logic [AW-1:0] a, input logic [15:0] w, input int rw);
        exp_t e;
        int   stbc;
        logic [15:0] f;
        e = '0;
        e.wr = wr;
        f = a[15:0] ^ 16'h5A3C;
        e.err = (sty[cs] == 2'd3) || (wr && !we[cs]) ||
                (!wr && byt && !nar[cs] && !b16[cs]);
        if (e.err) begin
            e.busy = 16'd1;
        end else begin
            stbc = (sty[cs] == 2'd2 && rw > int'(tst[cs])) ? rw + 1 : int'(tst[cs]) + 1;
            e.busy   = 16'((1 + ta[cs]) + (1 + ts[cs]) + stbc + (1 + th[cs]) + (1 + tr[cs]));
            e.csc    = 16'((1 + ts[cs]) + stbc + (1 + th[cs]));
            e.csmask = 8'(1 << cs);
            if (sty[cs] == 2'd0) begin
                if (wr) e.wrc = 16'(stbc); else e.rdc = 16'(stbc);
            end else begin
                e.dsc = 16'(stbc);
                if (wr) e.dswc = 16'(stbc);
            end
            if (mx[cs]) begin
                e.alec = 16'(1 + ta[cs]);
                e.aled = a[15:0];
            end
            if (wr) begin
                if (nar[cs])  e.wd = {8'h00, w[7:0]};
                else if (byt) e.wd = a[0] ? {w[7:0], 8'h00} : {8'h00, w[7:0]};
                else          e.wd = w;
            end else begin
                if (nar[cs])  e.rdata = {8'h00, f[7:0]};
                else if (byt) e.rdata = a[0] ? {8'h00, f[15:8]} : {8'h00, f[7:0]};
                else          e.rdata = f;
            end
        end
        do @(negedge clk); while (!req_ready);
        req_cs = 3'(cs); req_write = wr; req_byte = byt; req_addr = a; req_wdata = w;
        rdy_wait = rw; cur_pol = rh[cs];
        q.push_back(e);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: accumulates bus activity and compares at each completion
    int busy, csc, rdc, wrc, dsc, dswc, alec;
    logic [7:0]  csmask;
    logic [15:0] aled, wd;
    logic        prev_done = 1'b0;

    task automatic clear_mon;
        busy = 0; csc = 0; rdc = 0; wrc = 0; dsc = 0; dswc = 0; alec = 0;
        csmask = '0; aled = 16'hDEAD; wd = 16'hDEAD;
    endtask

    initial clear_mon();

    always @(negedge clk) begin
        if (!rst) begin
            exp_t e;
            if (!req_ready) busy++;
            if (bus_cs_n != '1) begin csc++; csmask = csmask | ~bus_cs_n; end
            if (!bus_rd_n) rdc++;
            if (!bus_wr_n) begin wrc++; wd = bus_d_oe ? bus_d_out : 16'hDEAD; end
            if (!bus_ds_n) begin
                dsc++;
                if (!bus_rnw) begin dswc++; wd = bus_d_oe ? bus_d_out : 16'hDEAD; end
            end
            if (bus_ale) begin alec++; aled = bus_d_oe ? bus_d_out : 16'hDEAD; end
            // R11: completion is a single-cycle pulse
            if (prev_done && rsp_done) chk("R11 done width", 2, 1);
            if (!rsp_done && rsp_err) chk("R11 err without done", 1, 0);
            if (rsp_done) begin
                if (q.size() == 0) chk("R11 unexpected done", 1, 0);
                else begin
                    e = q.pop_front();
                    chk("R9/R10 err flag", int'(rsp_err), int'(e.err));
                    chk("R11 rdata", int'(rsp_rdata), int'(e.rdata));
                    chk("R2 busy cycles", busy, int'(e.busy));
                    chk("R3 select cycles", csc, int'(e.csc));
                    chk("R1 select line", int'(csmask), int'(e.csmask));
                    chk("R4 rd strobe cycles", rdc, int'(e.rdc));
                    chk("R4 wr strobe cycles", wrc, int'(e.wrc));
                    chk("R5/R6 data strobe cycles", dsc, int'(e.dsc));
                    chk("R5 write-direction cycles", dswc, int'(e.dswc));
                    chk("R7 address latch cycles", alec, int'(e.alec));
                    if (e.alec != 0) chk("R7 muxed address", int'(aled), int'(e.aled));
                    if (e.wr && !e.err) chk("R8 write lanes", int'(wd), int'(e.wd));
                end
                clear_mon();
            end
            prev_done = rsp_done;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL R11 watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < NCS; i++) begin
            ta[i] = 0; ts[i] = 0; th[i] = 0; tst[i] = 0; tr[i] = 0; sty[i] = 0;
            nar[i] = 0; b16[i] = 0; mx[i] = 0; we[i] = 1; rh[i] = 1;
        end
        // cs1: single strobe, every phase stretched differently
        sty[1] = 2'd1; ta[1] = 2; ts[1] = 1; tst[1] = 3; th[1] = 2; tr[1] = 5;
        // cs2/cs3: host port with both ready polarities
        sty[2] = 2'd2; tst[2] = 2; rh[2] = 1;
        sty[3] = 2'd2; tst[3] = 1; rh[3] = 0; ts[3] = 3;
        // cs4: multiplexed address, split strobes
        mx[4] = 1; ta[4] = 3; tst[4] = 1;
        // cs5: 8-bit device
        nar[5] = 1; sty[5] = 2'd1;
        // cs6: 16-bit device, byte reads allowed
        b16[6] = 1; th[6] = 3;
        // cs7: writes disabled, byte reads not allowed
        we[7] = 0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk("R1 reset cs_n", int'(bus_cs_n), 255);
        chk("R4 reset strobes", int'({bus_rd_n, bus_wr_n, bus_ds_n}), 7);
        chk("R11 reset done", int'(rsp_done), 0);
        chk("R2 reset ready", int'(req_ready), 1);

        send(0, 0, 0, 24'h000124, 16'h0000, 0);   // R4 split read
        send(0, 1, 0, 24'h000200, 16'hBEEF, 0);   // R4 split write
        send(1, 0, 0, 24'h031000, 16'h0000, 0);   // R5 stretched read
        send(1, 1, 0, 24'h031002, 16'h1234, 0);   // R5 stretched write
        send(2, 0, 0, 24'h000010, 16'h0000, 6);   // R6 ready late
        send(2, 1, 0, 24'h000012, 16'h7777, 0);   // R6 ready early
        send(3, 0, 0, 24'h000020, 16'h0000, 4);   // R6 active-low ready
        send(4, 0, 0, 24'h00ABCD, 16'h0000, 0);   // R7 muxed read
        send(4, 1, 0, 24'h001357, 16'hCAFE, 0);   // R7 muxed write
        send(5, 1, 1, 24'h000041, 16'h99A5, 0);   // R8 narrow byte write
        send(5, 0, 0, 24'h000043, 16'h0000, 0);   // R8 narrow read
        send(6, 0, 1, 24'h000051, 16'h0000, 0);   // R8 odd byte read
        send(6, 0, 1, 24'h000050, 16'h0000, 0);   // R8 even byte read
        send(6, 1, 1, 24'h000053, 16'h00C3, 0);   // R8 odd byte write
        send(0, 1, 1, 24'h000060, 16'h003C, 0);   // R8 even byte write
        send(7, 1, 0, 24'h000070, 16'hFFFF, 0);   // R9 write disabled
        send(7, 0, 0, 24'h000072, 16'h0000, 0);   // R9 read still served
        send(7, 0, 1, 24'h000073, 16'h0000, 0);   // R10 byte read refused
        send(7, 1, 0, 24'h000074, 16'h5555, 0);   // R9 back-to-back error
        do @(negedge clk); while (!req_ready || q.size() != 0);
        sty[0] = 2'd3;
        send(0, 0, 0, 24'h000080, 16'h0000, 0);   // R10 reserved style
        do @(negedge clk); while (!req_ready || q.size() != 0);
        sty[0] = 2'd0;
        tst[1] = 15; tr[1] = 15; ta[1] = 3; ts[1] = 3; th[1] = 3;
        send(1, 0, 0, 24'h0000F0, 16'h0000, 0);   // R2 maximum extensions
        send(1, 1, 0, 24'h0000F2, 16'hA1B2, 0);

        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule